// File: doc/BRIEF.md
# Interrupt Pin Dispatcher With Multicast

The dispatcher watches a bank of interrupt input pins and turns each newly raised pin into interrupt messages on a valid/ready output port. Every pin has a routing entry, given on a flat input bus. The entry holds a vector, a delivery mode, a destination mode, a polarity, a trigger mode, a mask bit and an 8-bit destination. Each message carries a target ID, a vector and copies of the entry's mode bits.

In physical destination mode a single message goes to the entry's destination value. In logical mode the destination is read as a bitmask, and one message goes out per set bit, lowest bit first, with the target ID equal to the bit index. For the external-interrupt delivery mode, the vector is taken from a separate input driven by a legacy interrupt controller. Two delivery-mode codes are reserved. They never produce a message and raise a one-cycle error flag instead. Pin events that arrive while a multicast is still going out are held per pin, and the lowest-numbered pin is served first.

Top module: `irq_dispatch`

## Requirements
- R1: A message sequence starts only when a pin goes from low to high. A pin held high produces nothing further. Lowering a pin produces nothing and re-arms it for its next rise.
- R2: Bit 14 of a pin's entry is the mask bit. When it is 1 at service time, the event is dropped, no message is sent and `err_o` stays low.
- R3: Bits [10:8] of an entry give the delivery mode. When they equal 3'b111 (external interrupt), the message vector is `ext_vec_i`, sampled when the pin is serviced. For any other code the vector is entry bits [7:0].
- R4: Entry layout for pin p is `route_i[p*23 +: 23]`, with bit 11 the destination mode, bit 12 the polarity and bit 13 the trigger. Each message copies the delivery mode to `msg_mode_o`, the destination mode to `msg_dest_mode_o`, the polarity to `msg_level_o` and the trigger to `msg_trigger_o`.
- R5: With destination mode 0 (physical), exactly one message is sent, and `msg_dest_o` equals entry bits [22:15].
- R6: With destination mode 1 (logical), one message is sent per set bit of entry bits [22:15], in ascending bit order, with `msg_dest_o` equal to the bit index. A zero mask sends nothing.
- R7: Delivery-mode codes 3'b011 and 3'b110 send no message. Instead, `err_o` is high for exactly one cycle.
- R8: While `msg_valid_o` is high and `msg_ready_i` is low, the valid signal and every message field hold their values. After reset `msg_valid_o` and `err_o` are low.
- R9: Rises that occur while a sequence is in progress are kept pending per pin. Pending pins are served lowest pin number first once the current sequence ends.
- R10: A pin that rises before clock edge E with the block idle gives `msg_valid_o` (or `err_o`) high after edge E+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_PINS | Interrupt input pins |
| route_i | input | NUM_PINS*23 | Routing entries, 23 bits per pin |
| ext_vec_i | input | 8 | Vector from the legacy controller |
| msg_valid_o | output | 1 | Message valid |
| msg_ready_i | input | 1 | Message accepted when high with valid |
| msg_dest_o | output | 8 | Target ID |
| msg_vector_o | output | 8 | Interrupt vector |
| msg_mode_o | output | 3 | Delivery mode |
| msg_dest_mode_o | output | 1 | Destination mode, 0 physical, 1 logical |
| msg_level_o | output | 1 | Level bit (entry polarity) |
| msg_trigger_o | output | 1 | Trigger mode |
| err_o | output | 1 | One-cycle pulse on a reserved delivery mode |

## Verification
A pin rise passes through two registers: the pending latch at the first edge and the sequencer load at the second. The first message or error pulse therefore appears after the second edge. With ready held high, each following multicast message appears one cycle after the previous one. The bench drives inputs on the falling edge and samples midway through the low phase. The latency test checks that valid is still low one falling edge after the rise and high on the next. All other scenarios log every accepted message and error pulse each cycle. They wait a fixed window that is longer than the longest sequence, then compare the logged order and fields against expected values.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;
  localparam int VEC_W  = 8;
  localparam int DEST_W = 8;
  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] MODE_EXTINT = 3'b111;
  localparam logic [MODE_W-1:0] MODE_RSV_A  = 3'b011;
  localparam logic [MODE_W-1:0] MODE_RSV_B  = 3'b110;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              mask;
    logic              trigger;
    logic              polarity;
    logic              dest_mode;
    logic [MODE_W-1:0] mode;
    logic [VEC_W-1:0]  vector;
  } route_t;

  localparam int ENT_W = $bits(route_t);

  typedef enum logic {ST_IDLE, ST_SEND} seq_state_e;

  function automatic logic is_reserved(logic [MODE_W-1:0] m);
    return (m == MODE_RSV_A) || (m == MODE_RSV_B);
  endfunction
endpackage

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int W = 8,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req_i,
  output logic [W-1:0]  oh_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    oh_o  = '0;
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        oh_o    = '0;
        oh_o[i] = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/irq_edge_track.sv
module irq_edge_track #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  input  logic [N-1:0] grant_i,
  output logic [N-1:0] pending_o
);
  logic [N-1:0] level_q, pending_q, rise;

  assign rise = pin_i & ~level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q   <= '0;
      pending_q <= '0;
    end else begin
      level_q   <= pin_i;
      // a fresh rise wins over a same-cycle grant
      pending_q <= (pending_q & ~grant_i) | rise;
    end
  end

  assign pending_o = pending_q;

  p_rise_pending_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise != '0) |=> ((pending_q & $past(rise)) == $past(rise)));

  p_hold_no_rise_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_q == pin_i) |-> (rise == '0));
endmodule

// File: rtl/irq_msg_seq.sv
module irq_msg_seq
  import irq_dispatch_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N-1:0]         pending_i,
  input  logic [N*ENT_W-1:0]   route_i,
  input  logic [VEC_W-1:0]     ext_vec_i,
  output logic [N-1:0]         grant_o,
  output logic                 msg_valid_o,
  input  logic                 msg_ready_i,
  output logic [DEST_W-1:0]    msg_dest_o,
  output logic [VEC_W-1:0]     msg_vector_o,
  output logic [MODE_W-1:0]    msg_mode_o,
  output logic                 msg_dest_mode_o,
  output logic                 msg_level_o,
  output logic                 msg_trigger_o,
  output logic                 err_o
);
  localparam int IW  = (N > 1) ? $clog2(N) : 1;
  localparam int DIW = $clog2(DEST_W);

  route_t ents [N];
  for (genvar gi = 0; gi < N; gi++) begin : g_ent
    assign ents[gi] = route_t'(route_i[gi*ENT_W +: ENT_W]);
  end

  logic [N-1:0]      pend_oh;
  logic [IW-1:0]     pend_idx;
  logic              pend_any;
  logic [DEST_W-1:0] tgt_oh;
  logic [DIW-1:0]    tgt_idx;
  logic              tgt_any;

  seq_state_e        state_q, state_d;
  route_t            ent_q, ent_d, sel;
  logic [DEST_W-1:0] left_q, left_d;
  logic              err_q, err_d;

  irq_lowest_pick #(.W(N)) u_pend_pick (
    .req_i(pending_i), .oh_o(pend_oh), .idx_o(pend_idx), .any_o(pend_any)
  );

  irq_lowest_pick #(.W(DEST_W)) u_tgt_pick (
    .req_i(left_q), .oh_o(tgt_oh), .idx_o(tgt_idx), .any_o(tgt_any)
  );

  assign sel = ents[pend_idx];

  always_comb begin
    state_d = state_q;
    ent_d   = ent_q;
    left_d  = left_q;
    err_d   = 1'b0;
    grant_o = '0;
    case (state_q)
      ST_IDLE: begin
        if (pend_any) begin
          grant_o = pend_oh;
          if (!sel.mask) begin
            if (is_reserved(sel.mode)) begin
              err_d = 1'b1;
            end else if (!(sel.dest_mode && sel.dest == '0)) begin
              state_d      = ST_SEND;
              ent_d        = sel;
              ent_d.vector = (sel.mode == MODE_EXTINT) ? ext_vec_i : sel.vector;
              left_d       = sel.dest;
            end
          end
        end
      end
      ST_SEND: begin
        if (msg_ready_i) begin
          left_d = left_q & ~tgt_oh;
          if (!ent_q.dest_mode || left_d == '0) state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ent_q   <= '0;
      left_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ent_q   <= ent_d;
      left_q  <= left_d;
      err_q   <= err_d;
    end
  end

  assign msg_valid_o     = (state_q == ST_SEND);
  assign msg_dest_o      = ent_q.dest_mode ? DEST_W'(tgt_idx) : ent_q.dest;
  assign msg_vector_o    = ent_q.vector;
  assign msg_mode_o      = ent_q.mode;
  assign msg_dest_mode_o = ent_q.dest_mode;
  assign msg_level_o     = ent_q.polarity;
  assign msg_trigger_o   = ent_q.trigger;
  assign err_o           = err_q;

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && !msg_ready_i) |=> (msg_valid_o && $stable(msg_dest_o) &&
      $stable(msg_vector_o) && $stable(msg_mode_o) && $stable(msg_dest_mode_o) &&
      $stable(msg_level_o) && $stable(msg_trigger_o)));

  p_no_reserved_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> !is_reserved(msg_mode_o));

  p_err_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !msg_valid_o);

  p_no_masked_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> !ent_q.mask);

  p_logical_target_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_dest_mode_o) |-> tgt_any);

  p_ascend_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_ready_i && msg_dest_mode_o && left_d != '0)
      |=> (msg_valid_o && msg_dest_o > $past(msg_dest_o)));

  p_grant_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_dispatch_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_PINS-1:0]       pin_i,
  input  logic [NUM_PINS*ENT_W-1:0] route_i,
  input  logic [VEC_W-1:0]          ext_vec_i,
  output logic                      msg_valid_o,
  input  logic                      msg_ready_i,
  output logic [DEST_W-1:0]         msg_dest_o,
  output logic [VEC_W-1:0]          msg_vector_o,
  output logic [MODE_W-1:0]         msg_mode_o,
  output logic                      msg_dest_mode_o,
  output logic                      msg_level_o,
  output logic                      msg_trigger_o,
  output logic                      err_o
);
  logic [NUM_PINS-1:0] pending, grant;

  irq_edge_track #(.N(NUM_PINS)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i),
    .grant_i(grant), .pending_o(pending)
  );

  irq_msg_seq #(.N(NUM_PINS)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .pending_i(pending), .route_i(route_i),
    .ext_vec_i(ext_vec_i), .grant_o(grant), .msg_valid_o(msg_valid_o),
    .msg_ready_i(msg_ready_i), .msg_dest_o(msg_dest_o), .msg_vector_o(msg_vector_o),
    .msg_mode_o(msg_mode_o), .msg_dest_mode_o(msg_dest_mode_o),
    .msg_level_o(msg_level_o), .msg_trigger_o(msg_trigger_o), .err_o(err_o)
  );
endmodule

// File: tb/irq_dispatch_bench.sv
module irq_dispatch_bench;
  localparam int N  = 8;
  localparam int EW = 23;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  pin_i = '0;
  logic [N*EW-1:0] route_i = '0;
  logic [7:0]    ext_vec_i = '0;
  logic          msg_valid_o, msg_ready_i = 1'b1;
  logic [7:0]    msg_dest_o, msg_vector_o;
  logic [2:0]    msg_mode_o;
  logic          msg_dest_mode_o, msg_level_o, msg_trigger_o, err_o;

  irq_dispatch #(.NUM_PINS(N)) u_irq_dispatch (.*);

  always #10 clk_i = ~clk_i;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  logic [7:0] cap_dest [64];
  logic [7:0] cap_vec  [64];
  logic [2:0] cap_mode [64];
  logic [2:0] cap_bits [64];
  int cap_n = 0, err_n = 0;

  always begin
    @(negedge clk_i); #5;
    if (msg_valid_o && msg_ready_i && cap_n < 64) begin
      cap_dest[cap_n] = msg_dest_o;
      cap_vec[cap_n]  = msg_vector_o;
      cap_mode[cap_n] = msg_mode_o;
      cap_bits[cap_n] = {msg_dest_mode_o, msg_level_o, msg_trigger_o};
      cap_n++;
    end
    if (err_o) err_n++;
  end

  function automatic logic [EW-1:0] mk(logic [7:0] vec, logic [2:0] mode, logic dm,
                                      logic pol, logic trg, logic msk, logic [7:0] dest);
    return {dest, msk, trg, pol, dm, mode, vec};
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_cap();
    cap_n = 0; err_n = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse_pins(logic [N-1:0] m);
    @(negedge clk_i); pin_i = pin_i | m;
    idle(3);
    pin_i = pin_i & ~m;
  endtask

  task automatic t_reset();
    chk(msg_valid_o == 1'b0, "R8", "valid after reset", msg_valid_o, 0);
    chk(err_o == 1'b0, "R8", "err after reset", err_o, 0);
  endtask

  task automatic t_physical();
    route_i[3*EW +: EW] = mk(8'h41, 3'b001, 1'b0, 1'b1, 1'b0, 1'b0, 8'h9C);
    clear_cap();
    @(negedge clk_i); pin_i[3] = 1'b1;
    @(negedge clk_i);
    chk(msg_valid_o == 1'b0, "R10", "valid one edge after rise", msg_valid_o, 0);
    @(negedge clk_i);
    chk(msg_valid_o == 1'b1, "R10", "valid two edges after rise", msg_valid_o, 1);
    pin_i[3] = 1'b0;
    idle(6);
    chk(cap_n == 1, "R5", "physical message count", cap_n, 1);
    chk(cap_dest[0] == 8'h9C, "R5", "physical dest", cap_dest[0], 8'h9C);
    chk(cap_vec[0] == 8'h41, "R3", "entry vector", cap_vec[0], 8'h41);
    chk(cap_mode[0] == 3'b001, "R4", "mode copy", cap_mode[0], 1);
    chk(cap_bits[0] == 3'b010, "R4", "dm/level/trigger copy", cap_bits[0], 3'b010);
  endtask

  task automatic t_hold_lower();
    route_i[0 +: EW] = mk(8'h22, 3'b000, 1'b0, 1'b0, 1'b1, 1'b0, 8'h05);
    clear_cap();
    @(negedge clk_i); pin_i[0] = 1'b1;
    idle(12);
    chk(cap_n == 1, "R1", "held pin message count", cap_n, 1);
    pin_i[0] = 1'b0;
    idle(6);
    chk(cap_n == 1, "R1", "lowering sends nothing", cap_n, 1);
    pin_i[0] = 1'b1;
    idle(6);
    pin_i[0] = 1'b0;
    chk(cap_n == 2, "R1", "re-raise sends again", cap_n, 2);
    chk(cap_bits[1] == 3'b001, "R4", "trigger copy", cap_bits[1], 3'b001);
    idle(3);
  endtask

  task automatic t_masked();
    route_i[5*EW +: EW] = mk(8'h55, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 8'h01);
    clear_cap();
    pulse_pins(8'h20);
    idle(8);
    chk(cap_n == 0, "R2", "masked message count", cap_n, 0);
    chk(err_n == 0, "R2", "masked error count", err_n, 0);
  endtask

  task automatic t_ext();
    route_i[2*EW +: EW] = mk(8'h11, 3'b111, 1'b0, 1'b1, 1'b1, 1'b0, 8'h03);
    route_i[4*EW +: EW] = mk(8'h77, 3'b100, 1'b0, 1'b0, 1'b0, 1'b0, 8'h04);
    ext_vec_i = 8'h5A;
    clear_cap();
    pulse_pins(8'h04);
    idle(6);
    pulse_pins(8'h10);
    idle(6);
    chk(cap_n == 2, "R3", "ext message count", cap_n, 2);
    chk(cap_vec[0] == 8'h5A, "R3", "external vector", cap_vec[0], 8'h5A);
    chk(cap_mode[0] == 3'b111, "R4", "ext mode copy", cap_mode[0], 7);
    chk(cap_vec[1] == 8'h77, "R3", "non-ext uses entry vector", cap_vec[1], 8'h77);
  endtask

  task automatic t_logical();
    route_i[1*EW +: EW] = mk(8'h31, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 8'hA5);
    clear_cap();
    pulse_pins(8'h02);
    idle(10);
    chk(cap_n == 4, "R6", "logical message count", cap_n, 4);
    chk(cap_dest[0] == 0, "R6", "logical target 0", cap_dest[0], 0);
    chk(cap_dest[1] == 2, "R6", "logical target 1", cap_dest[1], 2);
    chk(cap_dest[2] == 5, "R6", "logical target 2", cap_dest[2], 5);
    chk(cap_dest[3] == 7, "R6", "logical target 3", cap_dest[3], 7);
    chk(cap_bits[3] == 3'b100, "R4", "logical dm copy", cap_bits[3], 3'b100);
    route_i[1*EW +: EW] = mk(8'h31, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    clear_cap();
    pulse_pins(8'h02);
    idle(8);
    chk(cap_n == 0, "R6", "empty logical mask", cap_n, 0);
  endtask

  task automatic t_reserved();
    route_i[6*EW +: EW] = mk(8'h66, 3'b011, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01);
    clear_cap();
    @(negedge clk_i); pin_i[6] = 1'b1;
    idle(2);
    chk(err_o == 1'b1, "R7", "err two edges after rise", err_o, 1);
    pin_i[6] = 1'b0;
    idle(6);
    route_i[6*EW +: EW] = mk(8'h66, 3'b110, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF);
    pulse_pins(8'h40);
    idle(6);
    chk(cap_n == 0, "R7", "reserved message count", cap_n, 0);
    chk(err_n == 2, "R7", "error pulses", err_n, 2);
  endtask

  task automatic t_backpressure();
    route_i[7*EW +: EW] = mk(8'h70, 3'b000, 1'b1, 1'b1, 1'b0, 1'b0, 8'h06);
    clear_cap();
    msg_ready_i = 1'b0;
    pulse_pins(8'h80);
    idle(4);
    chk(msg_valid_o == 1'b1, "R8", "valid held", msg_valid_o, 1);
    chk(msg_dest_o == 8'd1, "R8", "dest held", msg_dest_o, 1);
    chk(cap_n == 0, "R8", "nothing accepted", cap_n, 0);
    msg_ready_i = 1'b1;
    idle(6);
    chk(cap_n == 2, "R8", "messages after release", cap_n, 2);
    chk(cap_dest[1] == 8'd2, "R6", "second target", cap_dest[1], 2);
  endtask

  task automatic t_pending();
    route_i[6*EW +: EW] = mk(8'h60, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h0F);
    route_i[4*EW +: EW] = mk(8'h40, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h44);
    route_i[1*EW +: EW] = mk(8'h10, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h11);
    clear_cap();
    msg_ready_i = 1'b0;
    pulse_pins(8'h40);
    pulse_pins(8'h12);
    idle(2);
    msg_ready_i = 1'b1;
    idle(12);
    chk(cap_n == 6, "R9", "total messages", cap_n, 6);
    chk(cap_vec[3] == 8'h60 && cap_dest[3] == 3, "R9", "multicast finishes first",
        cap_vec[3], 8'h60);
    chk(cap_vec[4] == 8'h10, "R9", "lower pin next", cap_vec[4], 8'h10);
    chk(cap_vec[5] == 8'h40, "R9", "higher pin last", cap_vec[5], 8'h40);
  endtask

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(2);
    t_reset();
    t_physical();
    t_hold_lower();
    t_masked();
    t_ext();
    t_logical();
    t_reserved();
    t_backpressure();
    t_pending();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule